// File: doc/BRIEF.md
# Stretchable Quadrature CPU Clock Generator

This block derives the two quadrature clocks of a dynamic 8-bit processor, E and Q, from a single master clock. Both run at one quarter of the master rate, and Q leads E by one master period. The phase counter can be frozen while E is high and Q is low. This stretches the processor's data phase for two reasons: to wait for a slow backplane bus slave, or to bring the processor cycle into line with a separate, free-running, fixed-rate clock used by on-board I/O peripherals.

During a backplane stretch the block enables the backplane address and data buffers. It lowers the address and data strobes a parameterised number of master cycles later, which gives the strobes setup time. The stretch ends when the slave's response input goes low, after a two-stage synchronizer. A watchdog counter also ends it, so that a dynamic processor never has its clocks stopped long enough to lose register contents. When the watchdog ends a stretch, the block raises an active-low non-maskable interrupt request. That request stays asserted until software clears it.

The control is a three-state machine:
- `ST_RUN`: free-running.
- `ST_BUS_HOLD`: frozen for a backplane access.
- `ST_IO_HOLD`: frozen for I/O alignment.

Transitions:
- run→bus-hold: at the E rising phase with a backplane request.
- run→io-hold: at the E rising phase with an I/O request and no backplane request.
- bus-hold→run: on a synchronized acknowledge, or on watchdog expiry.
- io-hold→run: on the last master cycle of the I/O clock period.

Top module: `qclk_gen`

## Requirements
- R1: In reset cpu_q=0 and cpu_e=0. Out of reset, and with no stretch, the phases step every master cycle through (Q,E) = (1,0),(1,1),(0,1),(0,0) and repeat, so each clock has a 4-cycle period with Q leading E by one cycle.
- R2: bus_req and io_req are sampled only at the master edge that ends the (1,1) phase. A request present at any other edge has no effect. If both are high at that edge, the backplane stretch is taken.
- R3: In a backplane stretch, if resp_n is driven low d master cycles after the stretch starts, the stretch lasts d+SYNC_STAGES+1 master cycles. The default SYNC_STAGES is 2.
- R4: Every stretch holds (Q,E)=(0,1). Every stretch ends with a step to (0,0).
- R5: A backplane stretch lasts at most TMO_CYC master cycles; the default of 118 is about 8 µs at 14.7456 MHz. If an acknowledge and expiry fall on the same cycle, the acknowledge is taken.
- R6: A stretch ended by the watchdog drives nmi_n low at the releasing edge. nmi_n stays low until a clock edge with nmi_clr high. An acknowledged stretch leaves nmi_n high.
- R7: bus_buf_en is high in exactly the master cycles of a backplane stretch.
- R8: adr_stb_n and dat_stb_n go low ADR_DLY and DAT_DLY master cycles after bus_buf_en rises. Both defaults are 1. Both strobes rise at the same edge that lowers bus_buf_en.
- R9: io_e has a period of IO_DIV master cycles (default 9) and is high for the count values IO_DIV/2 to IO_DIV-1 of its counter. An I/O stretch ends so that cpu_e and io_e fall at the same edge. Its length is 1 to IO_DIV cycles, depending on the I/O clock phase at entry.
- R10: resp_n has no effect on cpu_e and cpu_q outside a backplane stretch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Current processor cycle targets the backplane |
| io_req | input | 1 | Current processor cycle targets an on-board fixed-rate peripheral |
| resp_n | input | 1 | Low when the slave acknowledges or signals a transfer error (asynchronous) |
| nmi_clr | input | 1 | Clears the pending timeout interrupt |
| cpu_e | output | 1 | Processor E clock |
| cpu_q | output | 1 | Processor Q clock (leads E) |
| io_e | output | 1 | Free-running fixed-rate peripheral clock |
| bus_buf_en | output | 1 | Backplane address/data buffer enable |
| adr_stb_n | output | 1 | Backplane address strobe, active low |
| dat_stb_n | output | 1 | Backplane data strobe, active low |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |

## Verification
A wrong phase register shows in the next master cycle as an E/Q pair out of sequence, or as a frozen pair other than (0,1). A fault in the watchdog or synchronizer shows when a stretch ends: the stretch length moves off d+3, or off the limit of 118 cycles, and nmi_n is wrong at the release edge. A broken I/O counter shows as cpu_e falling on an edge where io_e does not fall, or as a sweep of entry phases that misses some of the IO_DIV possible stretch lengths.

// File: rtl/qclk_pkg.sv
package qclk_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_BUS_HOLD = 2'd1,
        ST_IO_HOLD  = 2'd2
    } hold_state_t;

    // phase encoding: 0 Q rises, 1 E rises, 2 Q falls (freeze point), 3 E falls
    localparam logic [1:0] PH_QRISE = 2'd0;
    localparam logic [1:0] PH_ERISE = 2'd1;
    localparam logic [1:0] PH_QFALL = 2'd2;
    localparam logic [1:0] PH_EFALL = 2'd3;

endpackage

// File: rtl/qclk_sync.sv
module qclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/qclk_watchdog.sv
module qclk_watchdog #(
    parameter int TMO_CYC = 118
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    AST_WDOG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !expired || (TMO_CYC == 1)) else $error("watchdog not restarted"); // R5

endmodule

// File: rtl/qclk_io_tick.sv
module qclk_io_tick #(
    parameter int IO_DIV = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic io_e,
    output logic io_last
);
    localparam int CW = $clog2(IO_DIV);
    localparam logic [CW-1:0] LAST = CW'(IO_DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(IO_DIV / 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign io_e    = (cnt >= HALF);
    assign io_last = (cnt == LAST);

    AST_IO_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        io_last |=> !io_e) else $error("io clock did not fall at wrap"); // R9

endmodule

// File: rtl/qclk_strobe_dly.sv
module qclk_strobe_dly #(
    parameter int DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic stb_n
);
    logic [DLY-1:0] line;

    generate
        if (DLY == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) line <= '0;
                else        line <= en;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) line <= '0;
                else        line <= {line[DLY-2:0], en};
            end
        end
    endgenerate

    assign stb_n = !(en && line[DLY-1]);

    AST_STB_INSIDE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |-> en) else $error("strobe outside enable"); // R8
    AST_STB_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> stb_n) else $error("strobe without setup"); // R8

endmodule

// File: rtl/qclk_phase_fsm.sv
module qclk_phase_fsm
    import qclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        io_req,
    input  logic        ack_seen,
    input  logic        wd_expired,
    input  logic        io_last,
    output logic [1:0]  phase,
    output logic        bus_hold,
    output logic        timeout_hit,
    output logic        cpu_e,
    output logic        cpu_q
);
    hold_state_t state, state_nx;
    logic [1:0]  phase_nx;

    // next-state logic
    always_comb begin
        state_nx = state;
        phase_nx = phase;
        unique case (state)
            ST_RUN: begin
                phase_nx = phase + 2'd1;
                if (phase == PH_ERISE) begin
                    if (bus_req)     state_nx = ST_BUS_HOLD;
                    else if (io_req) state_nx = ST_IO_HOLD;
                end
            end
            ST_BUS_HOLD: begin
                if (ack_seen || wd_expired) begin
                    state_nx = ST_RUN;
                    phase_nx = PH_EFALL;
                end
            end
            ST_IO_HOLD: begin
                if (io_last) begin
                    state_nx = ST_RUN;
                    phase_nx = PH_EFALL;
                end
            end
            default: begin
                state_nx = ST_RUN;
                phase_nx = PH_EFALL;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            phase <= PH_EFALL;
        end else begin
            state <= state_nx;
            phase <= phase_nx;
        end
    end

    // outputs
    always_comb begin
        cpu_q       = (phase == PH_QRISE) || (phase == PH_ERISE);
        cpu_e       = (phase == PH_ERISE) || (phase == PH_QFALL);
        bus_hold    = (state == ST_BUS_HOLD);
        timeout_hit = (state == ST_BUS_HOLD) && wd_expired && !ack_seen;
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(phase == PH_ERISE && (bus_req || io_req)))
        |=> phase == $past(phase) + 2'd1) else $error("phase skipped"); // R1
    AST_FREEZE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> (cpu_e && !cpu_q)) else $error("frozen at wrong phase"); // R4
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUS_HOLD && ack_seen) |=> (state == ST_RUN && phase == PH_EFALL)) else $error("ack ignored"); // R3
    AST_WDOG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUS_HOLD && wd_expired) |=> (state == ST_RUN)) else $error("watchdog ignored"); // R5
    AST_IO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IO_HOLD && io_last) |=> (state == ST_RUN && !cpu_e)) else $error("io release late"); // R9
    AST_BUS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && phase == PH_ERISE && bus_req) |=> state == ST_BUS_HOLD) else $error("bus priority lost"); // R2

endmodule

// File: rtl/qclk_gen.sv
module qclk_gen #(
    parameter int TMO_CYC     = 118,
    parameter int IO_DIV      = 9,
    parameter int ADR_DLY     = 1,
    parameter int DAT_DLY     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    input  logic io_req,
    input  logic resp_n,
    input  logic nmi_clr,
    output logic cpu_e,
    output logic cpu_q,
    output logic io_e,
    output logic bus_buf_en,
    output logic adr_stb_n,
    output logic dat_stb_n,
    output logic nmi_n
);
    logic [1:0] phase;
    logic       resp_s;
    logic       bus_hold;
    logic       wd_expired;
    logic       timeout_hit;
    logic       io_last;
    logic       nmi_pend;

    qclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(resp_n), .q_sync(resp_s)
    );

    qclk_watchdog #(.TMO_CYC(TMO_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .run(bus_hold), .expired(wd_expired)
    );

    qclk_io_tick #(.IO_DIV(IO_DIV)) u_io (
        .clk(clk), .rst_n(rst_n), .io_e(io_e), .io_last(io_last)
    );

    qclk_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .io_req(io_req),
        .ack_seen(!resp_s), .wd_expired(wd_expired), .io_last(io_last),
        .phase(phase), .bus_hold(bus_hold), .timeout_hit(timeout_hit),
        .cpu_e(cpu_e), .cpu_q(cpu_q)
    );

    qclk_strobe_dly #(.DLY(ADR_DLY)) u_adr (
        .clk(clk), .rst_n(rst_n), .en(bus_hold), .stb_n(adr_stb_n)
    );

    qclk_strobe_dly #(.DLY(DAT_DLY)) u_dat (
        .clk(clk), .rst_n(rst_n), .en(bus_hold), .stb_n(dat_stb_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           nmi_pend <= 1'b0;
        else if (timeout_hit) nmi_pend <= 1'b1;
        else if (nmi_clr)     nmi_pend <= 1'b0;
    end

    assign nmi_n      = !nmi_pend;
    assign bus_buf_en = bus_hold;

    AST_NMI_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |=> !nmi_n) else $error("timeout not reported"); // R6
    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_n && !nmi_clr) |=> !nmi_n) else $error("nmi dropped"); // R6
    AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_buf_en && !cpu_e && cpu_q) |=> (cpu_e && cpu_q)) else $error("run phase disturbed"); // R10

endmodule

// File: tb/tb_qclk_gen.sv
module tb_qclk_gen;
    localparam int CLK_PERIOD = 10;
    localparam int TMO   = 118;
    localparam int NDIV  = 9;
    localparam int SYNC  = 2;
    localparam int SDLY  = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, io_req = 1'b0, resp_n = 1'b1, nmi_clr = 1'b0;
    logic cpu_e, cpu_q, io_e, bus_buf_en, adr_stb_n, dat_stb_n, nmi_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qclk_gen dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .io_req(io_req),
        .resp_n(resp_n), .nmi_clr(nmi_clr), .cpu_e(cpu_e), .cpu_q(cpu_q),
        .io_e(io_e), .bus_buf_en(bus_buf_en), .adr_stb_n(adr_stb_n),
        .dat_stb_n(dat_stb_n), .nmi_n(nmi_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic to_phase0();
        while (!(cpu_q && !cpu_e)) @(negedge clk);
    endtask

    // runs one backplane access, acknowledge d cycles into the stretch (d<0: never)
    task automatic bus_access(input int d);
        int len, exp_len;
        bit tmo;
        to_phase0();
        bus_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        len = 0;
        while (cpu_e && !cpu_q && len < 400) begin
            if (len == d) resp_n = 1'b0;
            chk(bus_buf_en == 1'b1, "R7 enable during stretch", bus_buf_en, 1);
            chk(adr_stb_n == (len < SDLY), "R8 address strobe", adr_stb_n, int'(len < SDLY));
            chk(dat_stb_n == (len < SDLY), "R8 data strobe", dat_stb_n, int'(len < SDLY));
            len++;
            @(negedge clk);
        end
        exp_len = (d >= 0 && d + SYNC + 1 <= TMO) ? d + SYNC + 1 : TMO;
        tmo = !(d >= 0 && d + SYNC + 1 <= TMO);
        chk(len == exp_len, (d < 0) ? "R5 watchdog length" : "R3 ack length", len, exp_len);
        chk(!cpu_e && !cpu_q, "R4 resume to E fall", {cpu_q, cpu_e}, 0);
        chk(nmi_n == !tmo, "R6 nmi at release", nmi_n, int'(!tmo));
        chk(bus_buf_en == 1'b0 && adr_stb_n && dat_stb_n, "R8 strobes drop with enable",
            {bus_buf_en, adr_stb_n, dat_stb_n}, 3);
        bus_req = 1'b0;
        resp_n  = 1'b1;
        if (tmo) begin
            repeat (5) @(negedge clk);
            chk(nmi_n == 1'b0, "R6 nmi held", nmi_n, 0);
            nmi_clr = 1'b1;
            @(negedge clk);
            nmi_clr = 1'b0;
            chk(nmi_n == 1'b1, "R6 nmi cleared", nmi_n, 1);
        end
    endtask

    initial begin
        bit pq, pe, eq, ee;
        bit [NDIV-1:0] seen;
        int len, frozen;

        repeat (3) @(negedge clk);
        chk(!cpu_e && !cpu_q, "R1 reset state", {cpu_q, cpu_e}, 0);
        rst_n = 1'b1;

        // R1 free-running sequence
        pq = cpu_q; pe = cpu_e;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            unique case ({pq, pe})
                2'b10: begin eq = 1; ee = 1; end
                2'b11: begin eq = 0; ee = 1; end
                2'b01: begin eq = 0; ee = 0; end
                default: begin eq = 1; ee = 0; end
            endcase
            chk(cpu_q == eq && cpu_e == ee, "R1 phase sequence", {cpu_q, cpu_e}, {eq, ee});
            pq = cpu_q; pe = cpu_e;
        end

        // R10 resp_n low while running
        resp_n = 1'b0;
        pq = cpu_q; pe = cpu_e;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            unique case ({pq, pe})
                2'b10: begin eq = 1; ee = 1; end
                2'b11: begin eq = 0; ee = 1; end
                2'b01: begin eq = 0; ee = 0; end
                default: begin eq = 1; ee = 0; end
            endcase
            chk(cpu_q == eq && cpu_e == ee, "R10 resp ignored when running", {cpu_q, cpu_e}, {eq, ee});
            chk(bus_buf_en == 1'b0, "R10 no enable", bus_buf_en, 0);
            pq = cpu_q; pe = cpu_e;
        end
        resp_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 request outside sampling edge is ignored
        while (!(cpu_e && !cpu_q)) @(negedge clk);
        bus_req = 1'b1; io_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_req = 1'b0; io_req = 1'b0;
        frozen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cpu_e && !cpu_q) frozen++;
            chk(bus_buf_en == 1'b0, "R2 late request no enable", bus_buf_en, 0);
        end
        chk(frozen == 2, "R2 late request no stretch", frozen, 2);

        // R2 priority with both requests: must take backplane path
        to_phase0();
        bus_req = 1'b1; io_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(bus_buf_en == 1'b1, "R2 backplane priority", bus_buf_en, 1);
        resp_n = 1'b0;
        while (cpu_e && !cpu_q) @(negedge clk);
        bus_req = 1'b0; io_req = 1'b0; resp_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 / R5 / R6 acknowledge delays, including the watchdog boundary
        bus_access(0);
        bus_access(3);
        bus_access(17);
        bus_access(60);
        bus_access(TMO - SYNC - 2);
        bus_access(TMO - SYNC - 1);
        bus_access(TMO - SYNC);
        bus_access(-1);

        // R9 I/O alignment sweep over entry phases
        seen = '0;
        for (int s = 0; s < 4 * NDIV; s++) begin
            repeat (s) @(negedge clk);
            to_phase0();
            io_req = 1'b1;
            @(negedge clk);
            @(negedge clk);
            len = 0;
            pe = io_e;
            while (cpu_e && !cpu_q && len < 40) begin
                chk(bus_buf_en == 1'b0, "R9 no backplane enable", bus_buf_en, 0);
                pe = io_e;
                len++;
                @(negedge clk);
            end
            io_req = 1'b0;
            chk(len >= 1 && len <= NDIV, "R9 stretch length range", len, NDIV);
            chk(pe == 1'b1 && io_e == 1'b0 && !cpu_e, "R9 E falls with io clock", {pe, io_e}, 2);
            if (len >= 1 && len <= NDIV) seen[len-1] = 1'b1;
        end
        chk(&seen, "R9 every io phase reached", int'(seen), (1 << NDIV) - 1);

        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!done) chk(1'b0, "watchdog expired", n, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule